// File: doc/BRIEF.md
# Tag-Renaming Register File

This block is the architectural register file of an out-of-order core that schedules dynamically. Each entry holds either a finished value or the tag of the in-flight instruction that will produce that value. Each cycle the issue stage presents two source register numbers. For each one it gets back either a ready value or the tag to wait for. In the same cycle it may rename a destination register, which marks that register as pending under a freshly built tag. The tag is the destination index with a rolling sequence number appended below it.

A result bus delivers a tag and a value. A register takes the value only if it is still pending under exactly that tag, so a result that a later rename has overtaken is dropped. The entries are written at the clock edge. For this reason, a source read in the same cycle as a matching broadcast takes the bus value directly.

There is no back-pressure on either side. The issue port and the result port are accepted in every cycle in which their valid is high, and there is no ready signal. Reads are combinational and show the state before that cycle's edge.

Top module: `tag_rename_regfile`

## Requirements
- R1: After reset every register reads as not pending with value 0, and the sequence number is 0.
- R2: A source read of a ready register gives pend=0, its value, and tag 0. A read of a pending register gives pend=1, its tag, and value 0.
- R3: An issue with iss_valid=1, iss_dst_en=1 and iss_dst not 0 makes iss_dst pending under iss_tag from the next cycle on. Source reads in the issue cycle itself still show the state before the rename. With iss_valid=0 or iss_dst_en=0, no register changes.
- R4: iss_tag is {iss_dst[4:0], seq[2:0]}, with the destination index in bits 7:3. seq advances by 1, modulo 8, only after an accepted rename.
- R5: A broadcast changes a register only if that register is pending and its stored tag equals res_tag. The register then becomes ready with res_data. A broadcast whose tag matches no pending register has no effect.
- R6: A source read of a pending register whose tag matches a valid broadcast in the same cycle returns pend=0 and res_data.
- R7: Register 0 always reads as ready with value 0. A rename of register 0 neither changes it nor advances seq.
- R8: If a rename and a matching broadcast hit the same register in one cycle, the rename wins and the register stays pending under the new tag.
- R9: The two read ports are independent, and both return the same result when they name the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue present this cycle |
| iss_src_a | input | 5 | Source register, port A |
| iss_src_b | input | 5 | Source register, port B |
| iss_dst | input | 5 | Destination register to rename |
| iss_dst_en | input | 1 | Issue writes a destination |
| iss_tag | output | 8 | Tag assigned to this issue |
| rd_a_pend | output | 1 | Port A operand is pending |
| rd_a_tag | output | 8 | Port A tag to wait for |
| rd_a_val | output | 32 | Port A operand value |
| rd_b_pend | output | 1 | Port B operand is pending |
| rd_b_tag | output | 8 | Port B tag to wait for |
| rd_b_val | output | 32 | Port B operand value |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | 8 | Tag of broadcast result |
| res_data | input | 32 | Broadcast result value |

## Verification
Some properties are checked by the assertions on every cycle: register 0 reads as ready zero, a pending tag always carries its own register index, no read shows a tag that is being broadcast in that cycle, seq steps only after a rename, and a renamed register reads as pending under the issued tag one cycle later. Other behaviour can only be shown by the bench scenarios, because it depends on history that spans several cycles. This covers dropping a stale broadcast whose tag is overtaken, the outcome of a rename racing a broadcast, wrap-around of the sequence number, and that a value stays in place after its broadcast.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned NREG  = 32;
  localparam int unsigned SEQW  = 3;
  localparam int unsigned NRDP  = 2;
  localparam int unsigned RIDXW = $clog2(NREG);
  localparam int unsigned TAGW  = RIDXW + SEQW;

  typedef logic [XLEN-1:0]  data_t;
  typedef logic [RIDXW-1:0] ridx_t;
  typedef logic [TAGW-1:0]  tag_t;

  typedef struct packed {
    logic  pend;
    tag_t  tag;
    data_t val;
  } rent_t;
endpackage

// File: rtl/rrf_tagalloc.sv
module rrf_tagalloc
  import rrf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  ridx_t dst,
  output tag_t  tag
);
  logic [SEQW-1:0] seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   seq_q <= '0;
    else if (adv) seq_q <= seq_q + 1'b1;
  end

  assign tag = {dst, seq_q};
endmodule

// File: rtl/rrf_entry.sv
module rrf_entry
  import rrf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ren,
  input  tag_t  new_tag,
  input  logic  bc_valid,
  input  tag_t  bc_tag,
  input  data_t bc_data,
  output rent_t ent
);
  rent_t q;
  logic  hit;

  // Only the still-current producer may write back
  assign hit = bc_valid && q.pend && (q.tag == bc_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (ren) begin
      // rename takes precedence over a same-cycle writeback
      q.pend <= 1'b1;
      q.tag  <= new_tag;
    end else if (hit) begin
      q.pend <= 1'b0;
      q.val  <= bc_data;
    end
  end

  assign ent = q;
endmodule

// File: rtl/rrf_rdport.sv
module rrf_rdport
  import rrf_pkg::*;
(
  input  ridx_t idx,
  input  rent_t ents [NREG],
  input  logic  bc_valid,
  input  tag_t  bc_tag,
  input  data_t bc_data,
  output logic  pend,
  output tag_t  tag,
  output data_t val
);
  rent_t e;

  always_comb begin
    e    = ents[idx];
    pend = 1'b0;
    tag  = '0;
    val  = '0;
    if (e.pend) begin
      if (bc_valid && (bc_tag == e.tag)) begin
        val = bc_data;
      end else begin
        pend = 1'b1;
        tag  = e.tag;
      end
    end else begin
      val = e.val;
    end
  end
endmodule

// File: rtl/tag_rename_regfile.sv
module tag_rename_regfile
  import rrf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [RIDXW-1:0] iss_src_a,
  input  logic [RIDXW-1:0] iss_src_b,
  input  logic [RIDXW-1:0] iss_dst,
  input  logic             iss_dst_en,
  output logic [TAGW-1:0]  iss_tag,
  output logic             rd_a_pend,
  output logic [TAGW-1:0]  rd_a_tag,
  output logic [XLEN-1:0]  rd_a_val,
  output logic             rd_b_pend,
  output logic [TAGW-1:0]  rd_b_tag,
  output logic [XLEN-1:0]  rd_b_val,
  input  logic             res_valid,
  input  logic [TAGW-1:0]  res_tag,
  input  logic [XLEN-1:0]  res_data
);
  rent_t regs [NREG];
  logic  ren_any;
  tag_t  new_tag;

  ridx_t rp_idx  [NRDP];
  logic  rp_pend [NRDP];
  tag_t  rp_tag  [NRDP];
  data_t rp_val  [NRDP];

  assign ren_any = iss_valid && iss_dst_en && (iss_dst != '0);

  rrf_tagalloc u_alloc (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (ren_any),
    .dst   (iss_dst),
    .tag   (new_tag)
  );
  assign iss_tag = new_tag;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_live
      rrf_entry u_ent (
        .clk      (clk),
        .rst_n    (rst_n),
        .ren      (ren_any && (iss_dst == ridx_t'(i))),
        .new_tag  (new_tag),
        .bc_valid (res_valid),
        .bc_tag   (res_tag),
        .bc_data  (res_data),
        .ent      (regs[i])
      );
    end
  end

  assign rp_idx[0] = iss_src_a;
  assign rp_idx[1] = iss_src_b;

  for (genvar p = 0; p < NRDP; p++) begin : g_rd
    rrf_rdport u_rd (
      .idx      (rp_idx[p]),
      .ents     (regs),
      .bc_valid (res_valid),
      .bc_tag   (res_tag),
      .bc_data  (res_data),
      .pend     (rp_pend[p]),
      .tag      (rp_tag[p]),
      .val      (rp_val[p])
    );
  end

  assign rd_a_pend = rp_pend[0];
  assign rd_a_tag  = rp_tag[0];
  assign rd_a_val  = rp_val[0];
  assign rd_b_pend = rp_pend[1];
  assign rd_b_tag  = rp_tag[1];
  assign rd_b_val  = rp_val[1];
endmodule

// File: rtl/rrf_checker.sv
module rrf_checker
  import rrf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic [RIDXW-1:0] iss_src_a,
  input logic [RIDXW-1:0] iss_src_b,
  input logic [RIDXW-1:0] iss_dst,
  input logic             iss_dst_en,
  input logic [TAGW-1:0]  iss_tag,
  input logic             rd_a_pend,
  input logic [TAGW-1:0]  rd_a_tag,
  input logic [XLEN-1:0]  rd_a_val,
  input logic             rd_b_pend,
  input logic [TAGW-1:0]  rd_b_tag,
  input logic [XLEN-1:0]  rd_b_val,
  input logic             res_valid,
  input logic [TAGW-1:0]  res_tag,
  input logic [XLEN-1:0]  res_data
);
  logic renamed;
  assign renamed = iss_valid && iss_dst_en && (iss_dst != '0);

  p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_src_a == '0) |-> (!rd_a_pend && rd_a_val == '0));

  p_tag_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_pend |-> (rd_b_tag[TAGW-1:SEQW] == iss_src_b));

  p_forward_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && rd_a_pend && rd_a_tag == res_tag));

  p_forward_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && rd_b_pend && rd_b_tag == res_tag));

  p_seq_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(renamed)) |->
      (iss_tag[SEQW-1:0] == $past(iss_tag[SEQW-1:0]) + 1'b1));

  p_seq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(renamed)) |->
      (iss_tag[SEQW-1:0] == $past(iss_tag[SEQW-1:0])));

  p_rename_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(renamed) && iss_src_a == $past(iss_dst)
      && !(res_valid && res_tag == $past(iss_tag)))
      |-> (rd_a_pend && rd_a_tag == $past(iss_tag)));
endmodule

bind tag_rename_regfile rrf_checker u_chk (.*);

// File: tb/tag_rename_regfile_tb_top.sv
module tag_rename_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0, iss_dst_en = 1'b0, res_valid = 1'b0;
  logic [4:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
  logic [7:0]  iss_tag, rd_a_tag, rd_b_tag, res_tag = '0;
  logic        rd_a_pend, rd_b_pend;
  logic [31:0] rd_a_val, rd_b_val, res_data = '0;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tag_rename_regfile dut_i (.*);

  typedef struct packed {
    logic        iv;  logic [4:0] sa; logic [4:0] sb; logic [4:0] dst; logic den;
    logic        bv;  logic [7:0] bt; logic [31:0] bd;
    logic        ap;  logic [31:0] av; logic [7:0] at;
    logic        bp;  logic [31:0] bvl; logic [7:0] btg;
    logic [7:0]  it;  logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // R1 state after reset
    '{0,0,5,0,0, 0,0,0,            0,0,0,   0,0,0,   0,1},
    // R3 rename r5 (tag 40), same-cycle reads see old state
    '{1,5,3,5,1, 0,0,0,            0,0,0,   0,0,0,   40,3},
    // R2 r5 pending under 40 on both ports
    '{0,5,5,0,0, 0,0,0,            1,0,40,  1,0,40,  1,2},
    // R6 matching broadcast forwarded
    '{0,5,0,0,0, 1,40,32'hAAAA0001, 0,32'hAAAA0001,0, 0,0,0, 1,6},
    // R5 value kept after writeback
    '{0,5,0,0,0, 0,0,0,            0,32'hAAAA0001,0, 0,0,0, 1,5},
    // R4 rename r7 gets tag 57
    '{1,7,5,7,1, 0,0,0,            0,0,0,   0,32'hAAAA0001,0, 57,4},
    // R5 non-matching broadcast not forwarded
    '{0,7,0,0,0, 1,58,32'h1234,    1,0,57,  0,0,0,   2,5},
    // R5 non-matching broadcast left r7 pending
    '{0,7,0,0,0, 0,0,0,            1,0,57,  0,0,0,   2,5},
    // R8 rename r7 (58) racing broadcast 57; read forwards
    '{1,7,0,7,1, 1,57,32'hBEEF,    0,32'hBEEF,0, 0,0,0, 58,8},
    // R8 rename won
    '{0,7,0,0,0, 0,0,0,            1,0,58,  0,0,0,   3,8},
    // R7 rename of r0 ignored
    '{1,0,0,0,1, 0,0,0,            0,0,0,   0,0,0,   3,7},
    // R7 r0 ignores broadcast, seq unchanged
    '{0,0,0,0,0, 1,0,32'hFFFF,     0,0,0,   0,0,0,   3,7},
    // R9 both ports forward same register
    '{0,7,7,0,0, 1,58,32'h55,      0,32'h55,0, 0,32'h55,0, 3,9},
    // R9 both ports read written value
    '{0,7,7,0,0, 0,0,0,            0,32'h55,0, 0,32'h55,0, 3,9}
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    iss_valid = v.iv; iss_src_a = v.sa; iss_src_b = v.sb;
    iss_dst = v.dst;  iss_dst_en = v.den;
    res_valid = v.bv; res_tag = v.bt;   res_data = v.bd;
  endtask

  task automatic check_vec(input vec_t v);
    check(v.req, "a_pend", 32'(rd_a_pend), 32'(v.ap));
    check(v.req, "a_val",  rd_a_val,       v.av);
    check(v.req, "a_tag",  32'(rd_a_tag),  32'(v.at));
    check(v.req, "b_pend", 32'(rd_b_pend), 32'(v.bp));
    check(v.req, "b_val",  rd_b_val,       v.bvl);
    check(v.req, "b_tag",  32'(rd_b_tag),  32'(v.btg));
    check(v.req, "iss_tag", 32'(iss_tag),  32'(v.it));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      #4;
      check_vec(VEC[i]);
      @(negedge clk);
    end
    // R4 sequence wrap: seq is 3, five renames of r9 go 3..7
    for (int k = 0; k < 5; k++) begin
      drive('{1,0,0,9,1, 0,0,0, 0,0,0, 0,0,0, 0,4});
      #4;
      check(4, "wrap tag", 32'(iss_tag), 32'(72 + ((3 + k) % 8)));
      @(negedge clk);
    end
    drive('{0,9,0,0,0, 0,0,0, 0,0,0, 0,0,0, 0,4});
    #4;
    check(4, "seq wrapped to 0", 32'(iss_tag), 32'd0);
    check(3, "r9 latest tag", 32'(rd_a_tag), 32'd79);
    check(3, "r9 pending", 32'(rd_a_pend), 32'd1);
    // R3 iss_valid low with dst_en: no rename
    @(negedge clk);
    drive('{0,3,0,3,1, 0,0,0, 0,0,0, 0,0,0, 0,3});
    @(negedge clk);
    drive('{0,3,0,0,0, 0,0,0, 0,0,0, 0,0,0, 0,3});
    #4;
    check(3, "no rename when not valid", 32'(rd_a_pend), 32'd0);
    check(4, "seq held when not valid", 32'(iss_tag), 32'd0);
    // R1 mid-run reset clears pending and values
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    drive('{0,7,9,0,0, 0,0,0, 0,0,0, 0,0,0, 0,1});
    #4;
    check(1, "r7 val after reset", rd_a_val, 32'd0);
    check(1, "r9 pend after reset", 32'(rd_b_pend), 32'd0);
    check(1, "seq after reset", 32'(iss_tag), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #200000;
    join_any
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule